// File: doc/BRIEF.md
# Core-to-Core Transfer Rendezvous

This block couples two processor cores through a blocking, single-word channel. Each core presents a transfer request with a direction (send or receive), a 4-bit target device code and a data word. Only requests aimed at the direct-link device code take part. The core that shows up first is held by its stall output. It stays held until the other core presents the complementary direction. In that cycle the sender's word appears on the receiver's read-data output, and both stall outputs are low together, so both cores carry on in lock-step.

A per-core watchdog counts how long a core has been held. If a core is held for more than the allowed number of cycles, its request is abandoned. The stall is lifted without new data, and a one-cycle timeout event for that core is sent out to the event aggregator. The two cores are symmetric. Either one may send and either one may receive.

Top module: `xfer_rendezvous`

## Requirements
- R1: A request takes part only when its request input is high and its device code equals the direct-link code (default 14, 4 bits). Any other request is ignored: no stall, no timeout, and read data unchanged.
- R2: A core with a taking-part request and no complementary partner has its stall output high.
- R3: When both cores take part with opposite directions (direction input 1 = send, 0 = receive), both stall outputs are low in that same cycle.
- R4: In the pairing cycle, the receiver's read-data output equals the sender's write data. It keeps that value after the requests drop, until the next transfer into that core.
- R5: Requests that arrive together in the same cycle pair with zero stall cycles.
- R6: Two sends, or two receives, never pair. Both cores stay stalled and neither read-data output changes.
- R7: A core that has been stalled for STALL_LIMIT consecutive cycles (default 1024) is aborted in the next cycle. In that cycle its stall output is low and its timeout output is high, for exactly one cycle.
- R8: An aborted core's read-data output keeps its previous value, and the other core raises no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c0_req_i | input | 1 | Core 0 transfer request |
| c0_is_send_i | input | 1 | Core 0 direction, 1 = send, 0 = receive |
| c0_dev_i | input | DEV_W | Core 0 target device code |
| c0_wdata_i | input | DATA_W | Core 0 outgoing word |
| c0_rdata_o | output | DATA_W | Core 0 received word |
| c0_stall_o | output | 1 | Core 0 held waiting for partner |
| c0_tmo_o | output | 1 | Core 0 timeout event pulse |
| c1_req_i | input | 1 | Core 1 transfer request |
| c1_is_send_i | input | 1 | Core 1 direction, 1 = send, 0 = receive |
| c1_dev_i | input | DEV_W | Core 1 target device code |
| c1_wdata_i | input | DATA_W | Core 1 outgoing word |
| c1_rdata_o | output | DATA_W | Core 1 received word |
| c1_stall_o | output | 1 | Core 1 held waiting for partner |
| c1_tmo_o | output | 1 | Core 1 timeout event pulse |

## Verification
The rendezvous is tried with a sender that arrives first, with a receiver that arrives first, and with both arriving in the same cycle. Together these show that the stall tracks only the waiting side and that data moves in the right direction whichever core leads. Matched directions (send with send, receive with receive) and a request aimed at a different device code separate true pairing from mere coincidence of requests. A lone receiver held to the full limit pins the abort to the exact cycle after STALL_LIMIT stall cycles and confirms that its read data is left untouched.

// File: rtl/xfer_rdv_pkg.sv
package xfer_rdv_pkg;
    // direction encoding on the is_send inputs
    typedef enum logic {
        DIR_RECV = 1'b0,
        DIR_SEND = 1'b1
    } xfer_dir_e;

    localparam int unsigned NUM_CORES = 2;
endpackage

// File: rtl/xfer_rdv_match.sv
module xfer_rdv_match #(
    parameter int unsigned DEV_W      = 4,
    parameter int unsigned DEV_DIRECT = 14
) (
    input  logic [1:0]       req_i,
    input  logic [1:0]       is_send_i,
    input  logic [DEV_W-1:0] dev_i [2],
    output logic [1:0]       active_o,
    output logic             paired_o,
    output logic             rx_idx_o
);
    import xfer_rdv_pkg::*;

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            active_o[i] = req_i[i] && (dev_i[i] == DEV_W'(DEV_DIRECT));
        end
        paired_o = (&active_o) && (is_send_i[0] != is_send_i[1]);
        // when core 0 sends, core 1 is the receiver
        rx_idx_o = (is_send_i[0] == DIR_SEND);
    end
endmodule

// File: rtl/xfer_rdv_timer.sv
module xfer_rdv_timer #(
    parameter int unsigned STALL_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_i,
    output logic stall_o,
    output logic tmo_o
);
    localparam int unsigned CNT_W = $clog2(STALL_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic expired;

    always_comb begin
        tmr_d   = tmr_q;
        expired = wait_i && (tmr_q.cnt == CNT_W'(STALL_LIMIT));
        tmo_o   = expired;
        stall_o = wait_i && !expired;
        if (stall_o) begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end else begin
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/xfer_rendezvous.sv
module xfer_rendezvous #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned DEV_W       = 4,
    parameter int unsigned DEV_DIRECT  = 14,
    parameter int unsigned STALL_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_req_i,
    input  logic              c0_is_send_i,
    input  logic [DEV_W-1:0]  c0_dev_i,
    input  logic [DATA_W-1:0] c0_wdata_i,
    output logic [DATA_W-1:0] c0_rdata_o,
    output logic              c0_stall_o,
    output logic              c0_tmo_o,
    input  logic              c1_req_i,
    input  logic              c1_is_send_i,
    input  logic [DEV_W-1:0]  c1_dev_i,
    input  logic [DATA_W-1:0] c1_wdata_i,
    output logic [DATA_W-1:0] c1_rdata_o,
    output logic              c1_stall_o,
    output logic              c1_tmo_o
);
    import xfer_rdv_pkg::*;

    typedef struct packed {
        logic [NUM_CORES-1:0][DATA_W-1:0] rd;
    } rdv_t;

    rdv_t rdv_d, rdv_q;

    logic [1:0]        req, is_send, active, stall, tmo;
    logic [DEV_W-1:0]  dev   [2];
    logic [DATA_W-1:0] wdata [2];
    logic              paired, rx_idx;

    assign req     = {c1_req_i, c0_req_i};
    assign is_send = {c1_is_send_i, c0_is_send_i};
    assign dev[0]  = c0_dev_i;
    assign dev[1]  = c1_dev_i;
    assign wdata[0] = c0_wdata_i;
    assign wdata[1] = c1_wdata_i;

    xfer_rdv_match #(
        .DEV_W      (DEV_W),
        .DEV_DIRECT (DEV_DIRECT)
    ) u_match (
        .req_i     (req),
        .is_send_i (is_send),
        .dev_i     (dev),
        .active_o  (active),
        .paired_o  (paired),
        .rx_idx_o  (rx_idx)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        xfer_rdv_timer #(
            .STALL_LIMIT (STALL_LIMIT)
        ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .wait_i  (active[g] && !paired),
            .stall_o (stall[g]),
            .tmo_o   (tmo[g])
        );
    end

    always_comb begin
        rdv_d = rdv_q;
        if (paired) begin
            rdv_d.rd[rx_idx] = wdata[~rx_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdv_q <= '0;
        end else begin
            rdv_q <= rdv_d;
        end
    end

    // the receiver sees the word already in the release cycle
    assign c0_rdata_o = rdv_d.rd[0];
    assign c1_rdata_o = rdv_d.rd[1];
    assign c0_stall_o = stall[0];
    assign c1_stall_o = stall[1];
    assign c0_tmo_o   = tmo[0];
    assign c1_tmo_o   = tmo[1];
endmodule

// File: rtl/xfer_rendezvous_chk.sv
module xfer_rendezvous_chk #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned DEV_W       = 4,
    parameter int unsigned DEV_DIRECT  = 14,
    parameter int unsigned STALL_LIMIT = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              c0_req_i,
    input logic              c0_is_send_i,
    input logic [DEV_W-1:0]  c0_dev_i,
    input logic [DATA_W-1:0] c0_wdata_i,
    input logic [DATA_W-1:0] c0_rdata_o,
    input logic              c0_stall_o,
    input logic              c0_tmo_o,
    input logic              c1_req_i,
    input logic              c1_is_send_i,
    input logic [DEV_W-1:0]  c1_dev_i,
    input logic [DATA_W-1:0] c1_wdata_i,
    input logic [DATA_W-1:0] c1_rdata_o,
    input logic              c1_stall_o,
    input logic              c1_tmo_o
);
    localparam int unsigned RUN_W = $clog2(STALL_LIMIT + 2);

    logic on0, on1, pair, rx0, rx1;
    logic [RUN_W-1:0] run0_q, run1_q;

    assign on0  = c0_req_i && (c0_dev_i == DEV_W'(DEV_DIRECT));
    assign on1  = c1_req_i && (c1_dev_i == DEV_W'(DEV_DIRECT));
    assign pair = on0 && on1 && (c0_is_send_i != c1_is_send_i);
    assign rx0  = pair && !c0_is_send_i;
    assign rx1  = pair && !c1_is_send_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run0_q <= '0;
            run1_q <= '0;
        end else begin
            run0_q <= c0_stall_o ? run0_q + RUN_W'(1) : '0;
            run1_q <= c1_stall_o ? run1_q + RUN_W'(1) : '0;
        end
    end

    assert_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!on0 |-> !c0_stall_o && !c0_tmo_o) and (!on1 |-> !c1_stall_o && !c1_tmo_o));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair |-> !c0_stall_o && !c1_stall_o && !c0_tmo_o && !c1_tmo_o);

    assert_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx0 |-> c0_rdata_o == c1_wdata_i) and (rx1 |-> c1_rdata_o == c0_wdata_i));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx0 |=> $stable(c0_rdata_o) || rx0) and (!rx1 |=> $stable(c1_rdata_o) || rx1));

    assert_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_stall_o |-> run0_q < RUN_W'(STALL_LIMIT)) and
        (c1_stall_o |-> run1_q < RUN_W'(STALL_LIMIT)));

    assert_tmo_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_tmo_o |-> run0_q == RUN_W'(STALL_LIMIT)) and
        (c1_tmo_o |-> run1_q == RUN_W'(STALL_LIMIT)));

    assert_tmo_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_tmo_o |=> !c0_tmo_o) and (c1_tmo_o |=> !c1_tmo_o));
endmodule

bind xfer_rendezvous xfer_rendezvous_chk #(
    .DATA_W      (DATA_W),
    .DEV_W       (DEV_W),
    .DEV_DIRECT  (DEV_DIRECT),
    .STALL_LIMIT (STALL_LIMIT)
) u_chk (.*);

// File: tb/tb_xfer_rendezvous.sv
module tb_xfer_rendezvous;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 1024;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        c0_req = 0, c0_send = 0, c1_req = 0, c1_send = 0;
    logic [3:0]  c0_dev = 0, c1_dev = 0;
    logic [31:0] c0_wd = 0, c1_wd = 0;
    logic [31:0] c0_rd, c1_rd;
    logic        c0_st, c0_to, c1_st, c1_to;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] exp0 = 0, exp1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_rendezvous dut (
        .clk(clk), .rst_n(rst_n),
        .c0_req_i(c0_req), .c0_is_send_i(c0_send), .c0_dev_i(c0_dev), .c0_wdata_i(c0_wd),
        .c0_rdata_o(c0_rd), .c0_stall_o(c0_st), .c0_tmo_o(c0_to),
        .c1_req_i(c1_req), .c1_is_send_i(c1_send), .c1_dev_i(c1_dev), .c1_wdata_i(c1_wd),
        .c1_rdata_o(c1_rd), .c1_stall_o(c1_st), .c1_tmo_o(c1_to)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic next();
        @(negedge clk);
    endtask

    task automatic idle();
        c0_req = 0; c1_req = 0;
    endtask

    task automatic t_reset();
        check("R2 reset c0 stall", {31'b0, c0_st}, 0);
        check("R2 reset c1 stall", {31'b0, c1_st}, 0);
        check("R7 reset tmo", {30'b0, c0_to, c1_to}, 0);
        check("R4 reset c0 rdata", c0_rd, 0);
        check("R4 reset c1 rdata", c1_rd, 0);
    endtask

    task automatic t_c0_leads(input logic [31:0] w);
        next();
        c0_req = 1; c0_send = 1; c0_dev = 14; c0_wd = w;
        #1;
        for (int i = 0; i < 5; i++) begin
            check("R2 sender waits", {31'b0, c0_st}, 1);
            check("R2 idle partner", {31'b0, c1_st}, 0);
            check("R6 rdata still", c1_rd, exp1);
            next(); #1;
        end
        c1_req = 1; c1_send = 0; c1_dev = 14;
        #1;
        exp1 = w;
        check("R3 c0 released", {31'b0, c0_st}, 0);
        check("R3 c1 released", {31'b0, c1_st}, 0);
        check("R4 c1 receives", c1_rd, exp1);
        check("R4 c0 untouched", c0_rd, exp0);
        next(); idle(); #1;
        check("R4 c1 holds", c1_rd, exp1);
        check("R3 quiet", {30'b0, c0_st, c1_st}, 0);
    endtask

    task automatic t_c1_leads(input logic [31:0] w);
        next();
        c0_req = 1; c0_send = 0; c0_dev = 14;
        #1;
        for (int i = 0; i < 3; i++) begin
            check("R2 receiver waits", {31'b0, c0_st}, 1);
            next(); #1;
        end
        c1_req = 1; c1_send = 1; c1_dev = 14; c1_wd = w;
        #1;
        exp0 = w;
        check("R3 both released", {30'b0, c0_st, c1_st}, 0);
        check("R4 c0 receives", c0_rd, exp0);
        next(); idle(); #1;
        check("R4 c0 holds", c0_rd, exp0);
    endtask

    task automatic t_together(input logic [31:0] w);
        next();
        c0_req = 1; c0_send = 0; c0_dev = 14;
        c1_req = 1; c1_send = 1; c1_dev = 14; c1_wd = w;
        #1;
        exp0 = w;
        check("R5 no stall", {30'b0, c0_st, c1_st}, 0);
        check("R5 data passed", c0_rd, exp0);
        next(); idle(); #1;
        check("R5 data held", c0_rd, exp0);
    endtask

    task automatic t_same_dir(input logic snd);
        next();
        c0_req = 1; c0_send = snd; c0_dev = 14; c0_wd = 32'hAAAA_0000;
        c1_req = 1; c1_send = snd; c1_dev = 14; c1_wd = 32'h0000_5555;
        #1;
        for (int i = 0; i < 4; i++) begin
            check("R6 both stall", {30'b0, c0_st, c1_st}, 2'b11);
            check("R6 c0 rdata", c0_rd, exp0);
            check("R6 c1 rdata", c1_rd, exp1);
            next(); #1;
        end
        idle(); #1;
        check("R6 released on drop", {30'b0, c0_st, c1_st}, 0);
    endtask

    task automatic t_wrong_dev(input logic [31:0] w);
        next();
        c0_req = 1; c0_send = 0; c0_dev = 13;
        c1_req = 1; c1_send = 1; c1_dev = 14; c1_wd = w;
        #1;
        for (int i = 0; i < 4; i++) begin
            check("R1 other code no stall", {31'b0, c0_st}, 0);
            check("R1 other code no data", c0_rd, exp0);
            check("R2 lone sender stalls", {31'b0, c1_st}, 1);
            next(); #1;
        end
        check("R1 no tmo", {31'b0, c0_to}, 0);
        idle(); #1;
    endtask

    task automatic t_timeout();
        next();
        c0_req = 1; c0_send = 0; c0_dev = 14;
        #1;
        check("R7 first stall", {31'b0, c0_st}, 1);
        for (int i = 1; i < LIMIT; i++) begin
            next(); #1;
            if (c0_st !== 1'b1 || c0_to !== 1'b0) begin
                check("R7 held until limit", {30'b0, c0_st, c0_to}, 2'b10);
            end
        end
        check("R7 last stall cycle", {31'b0, c0_st}, 1);
        next(); #1;
        check("R7 abort stall", {31'b0, c0_st}, 0);
        check("R7 abort tmo", {31'b0, c0_to}, 1);
        check("R8 aborted rdata", c0_rd, exp0);
        check("R8 other tmo", {31'b0, c1_to}, 0);
        idle();
        next(); #1;
        check("R7 pulse ends", {31'b0, c0_to}, 0);
        check("R8 rdata kept", c0_rd, exp0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        next(); rst_n = 1; #1;
        t_reset();
        t_c0_leads(32'hDEAD_BEEF);
        t_c1_leads(32'h1234_5678);
        t_together(32'hCAFE_F00D);
        t_same_dir(1'b1);
        t_same_dir(1'b0);
        t_wrong_dev(32'h0BAD_0BAD);
        t_timeout();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule